// File: doc/BRIEF.md
# Clock Display Character Formatter

This block sits between a 12-hour time-of-day counter and a character-LCD writer. It takes the BCD time fields and the AM/PM flag, and it returns nine ASCII character bytes: two for the AM/PM marker, two for the hour, two for the minute, a colon in front of the seconds, and two seconds digits. The LCD writer copies these bytes into its character memory. The block has no clock and no state: every output is a function of the present inputs.

The block also implements the edit-mode blinking. A one-hot mode vector says which field the user is editing, and a blink phase bit comes from an external half-second toggle. While the blink phase is low, the characters of the field under edit are replaced by spaces. In the initial (power-up) mode the whole time blinks as one unit. In the normal running mode nothing blinks and the seconds become visible. A zero hour-tens digit is always shown as a space, so that the hour reads " 9" and never "09".

Top module: `clk_disp_fmt`

## Requirements
- R1: The first marker character is 'A' (0x41) when `ampm_i` is 0 and 'P' (0x50) when it is 1. The second marker character is 'M' (0x4D). Both apply whenever the marker is not hidden.
- R2: A visible digit character is 0x30 plus its BCD value. This holds for hour units, minute tens, minute units, second tens and second units.
- R3: The hour-tens character is a space (0x20) whenever `hour_tens_i` is 0. When `hour_tens_i` is 1 and the hour is visible, the character is '1' (0x31).
- R4: The mode bits are: bit0 initial, bit1 AM/PM edit, bit2 hour edit, bit3 minute-tens edit, bit4 minute-units edit, bit5 normal. In initial mode with `blink_on_i` = 0, both marker characters, both hour characters and both minute characters are 0x20. With `blink_on_i` = 1, all of them are visible.
- R5: In AM/PM edit mode, only the two marker characters follow the blink bit. They are 0x20 when it is 0. The hour and minute characters stay visible.
- R6: In hour edit mode, only the two hour characters follow the blink bit. The marker and minute characters stay visible.
- R7: In minute-tens edit mode, only the minute-tens character follows the blink bit.
- R8: In minute-units edit mode, only the minute-units character follows the blink bit.
- R9: In normal mode, no character is hidden for either value of the blink bit. The seconds colon is ':' (0x3A), and both seconds digits are shown as in R2.
- R10: In every mode other than normal, the seconds colon and both seconds digits are 0x20, whatever the blink bit is.
- R11: A mode vector that is not exactly one-hot gives the same outputs as normal mode. This covers all-zero vectors and vectors with more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 6 | One-hot display mode (bit order given in R4) |
| blink_on_i | input | 1 | Blink phase: 1 shows the field under edit, 0 hides it |
| ampm_i | input | 1 | 0 = AM, 1 = PM |
| hour_tens_i | input | 1 | Hour tens digit (0 or 1) |
| hour_units_i | input | 4 | Hour units, BCD |
| min_tens_i | input | 3 | Minute tens, 0 to 5 |
| min_units_i | input | 4 | Minute units, BCD |
| sec_tens_i | input | 3 | Second tens, 0 to 5 |
| sec_units_i | input | 4 | Second units, BCD |
| ch_ap_o | output | 8 | Marker character 'A' / 'P' / space |
| ch_m_o | output | 8 | Marker character 'M' / space |
| ch_hr_tens_o | output | 8 | Hour tens character |
| ch_hr_units_o | output | 8 | Hour units character |
| ch_mn_tens_o | output | 8 | Minute tens character |
| ch_mn_units_o | output | 8 | Minute units character |
| ch_colon_o | output | 8 | Seconds colon character |
| ch_sc_tens_o | output | 8 | Second tens character |
| ch_sc_units_o | output | 8 | Second units character |

## Verification
Each of the six single-bit modes is applied with the blink bit low and then high. This separates the characters that a given mode hides from the characters it must leave alone. The digit values are varied across 0 to 9 (and 0 to 5 for the tens fields), with different values in every field, so that a swapped field or a wrong ASCII offset shows up. The AM/PM flag is toggled, and the hour-tens bit is tested at both 0 and 1. Mode vectors that are all zero or have two bits set are applied with the blink bit low. This makes them distinguishable from every edit mode, as R11 requires.

// File: rtl/clk_fmt_pkg.sv
package clk_fmt_pkg;

    localparam int CHAR_W = 8;
    localparam int MODE_W = 6;

    localparam logic [CHAR_W-1:0] CH_SPACE = 8'h20;
    localparam logic [CHAR_W-1:0] CH_ZERO  = 8'h30;
    localparam logic [CHAR_W-1:0] CH_ONE   = 8'h31;
    localparam logic [CHAR_W-1:0] CH_COLON = 8'h3A;
    localparam logic [CHAR_W-1:0] CH_A     = 8'h41;
    localparam logic [CHAR_W-1:0] CH_P     = 8'h50;
    localparam logic [CHAR_W-1:0] CH_M     = 8'h4D;

    // bit positions inside the one-hot mode vector
    localparam int MB_INIT  = 0;
    localparam int MB_APSET = 1;
    localparam int MB_HRSET = 2;
    localparam int MB_MTSET = 3;
    localparam int MB_MUSET = 4;
    localparam int MB_NORM  = 5;

    typedef struct packed {
        logic ap;     // marker characters hidden
        logic hr;     // hour characters hidden
        logic mt;     // minute tens hidden
        logic mu;     // minute units hidden
        logic secs;   // colon and seconds blanked
    } hide_t;

endpackage

// File: rtl/clk_fmt_mode_dec.sv
module clk_fmt_mode_dec
    import clk_fmt_pkg::*;
#(
    parameter int MW = MODE_W
) (
    input  logic [MW-1:0] mode_i,
    input  logic          blink_on_i,
    output hide_t         hide_o
);

    logic [MW-1:0] mode_eff_d;
    hide_t         hide_d;

    always_comb begin
        // anything other than exactly one bit falls back to normal
        if ($onehot(mode_i)) mode_eff_d = mode_i;
        else begin
            mode_eff_d          = '0;
            mode_eff_d[MB_NORM] = 1'b1;
        end

        hide_d.ap   = !blink_on_i && (mode_eff_d[MB_INIT] || mode_eff_d[MB_APSET]);
        hide_d.hr   = !blink_on_i && (mode_eff_d[MB_INIT] || mode_eff_d[MB_HRSET]);
        hide_d.mt   = !blink_on_i && (mode_eff_d[MB_INIT] || mode_eff_d[MB_MTSET]);
        hide_d.mu   = !blink_on_i && (mode_eff_d[MB_INIT] || mode_eff_d[MB_MUSET]);
        hide_d.secs = !mode_eff_d[MB_NORM];
    end

    assign hide_o = hide_d;

endmodule

// File: rtl/clk_fmt_digit.sv
module clk_fmt_digit
    import clk_fmt_pkg::*;
#(
    parameter int VW = 4
) (
    input  logic [VW-1:0]     val_i,
    input  logic              hide_i,
    output logic [CHAR_W-1:0] char_o
);

    localparam int PAD_W = CHAR_W - VW;

    always_comb begin
        if (hide_i) char_o = CH_SPACE;
        else        char_o = CH_ZERO + {{PAD_W{1'b0}}, val_i};
    end

endmodule

// File: rtl/clk_disp_fmt.sv
module clk_disp_fmt
    import clk_fmt_pkg::*;
#(
    parameter int DIG_W  = 4,
    parameter int TENS_W = 3
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic              blink_on_i,
    input  logic              ampm_i,
    input  logic              hour_tens_i,
    input  logic [DIG_W-1:0]  hour_units_i,
    input  logic [TENS_W-1:0] min_tens_i,
    input  logic [DIG_W-1:0]  min_units_i,
    input  logic [TENS_W-1:0] sec_tens_i,
    input  logic [DIG_W-1:0]  sec_units_i,
    output logic [CHAR_W-1:0] ch_ap_o,
    output logic [CHAR_W-1:0] ch_m_o,
    output logic [CHAR_W-1:0] ch_hr_tens_o,
    output logic [CHAR_W-1:0] ch_hr_units_o,
    output logic [CHAR_W-1:0] ch_mn_tens_o,
    output logic [CHAR_W-1:0] ch_mn_units_o,
    output logic [CHAR_W-1:0] ch_colon_o,
    output logic [CHAR_W-1:0] ch_sc_tens_o,
    output logic [CHAR_W-1:0] ch_sc_units_o
);

    localparam int NDIG   = 5;
    localparam int TPAD_W = DIG_W - TENS_W;

    hide_t hide_d;

    clk_fmt_mode_dec #(.MW(MODE_W)) u_dec (
        .mode_i     (mode_i),
        .blink_on_i (blink_on_i),
        .hide_o     (hide_d)
    );

    // digit lanes: 0 hr units, 1 min tens, 2 min units, 3 sec tens, 4 sec units
    logic [DIG_W-1:0]  dig_val_d  [NDIG];
    logic              dig_hide_d [NDIG];
    logic [CHAR_W-1:0] dig_char_d [NDIG];

    always_comb begin
        dig_val_d[0]  = hour_units_i;
        dig_val_d[1]  = {{TPAD_W{1'b0}}, min_tens_i};
        dig_val_d[2]  = min_units_i;
        dig_val_d[3]  = {{TPAD_W{1'b0}}, sec_tens_i};
        dig_val_d[4]  = sec_units_i;
        dig_hide_d[0] = hide_d.hr;
        dig_hide_d[1] = hide_d.mt;
        dig_hide_d[2] = hide_d.mu;
        dig_hide_d[3] = hide_d.secs;
        dig_hide_d[4] = hide_d.secs;
    end

    for (genvar gi = 0; gi < NDIG; gi++) begin : g_dig
        clk_fmt_digit #(.VW(DIG_W)) u_dig (
            .val_i  (dig_val_d[gi]),
            .hide_i (dig_hide_d[gi]),
            .char_o (dig_char_d[gi])
        );
    end

    always_comb begin
        ch_ap_o       = hide_d.ap ? CH_SPACE : (ampm_i ? CH_P : CH_A);
        ch_m_o        = hide_d.ap ? CH_SPACE : CH_M;
        ch_hr_tens_o  = (hide_d.hr || !hour_tens_i) ? CH_SPACE : CH_ONE;
        ch_colon_o    = hide_d.secs ? CH_SPACE : CH_COLON;
        ch_hr_units_o = dig_char_d[0];
        ch_mn_tens_o  = dig_char_d[1];
        ch_mn_units_o = dig_char_d[2];
        ch_sc_tens_o  = dig_char_d[3];
        ch_sc_units_o = dig_char_d[4];
    end

endmodule

// File: rtl/clk_disp_fmt_chk.sv
module clk_disp_fmt_chk
    import clk_fmt_pkg::*;
#(
    parameter int DIG_W  = 4,
    parameter int TENS_W = 3
) (
    input logic [MODE_W-1:0] mode_i,
    input logic              blink_on_i,
    input logic              ampm_i,
    input logic              hour_tens_i,
    input logic [DIG_W-1:0]  hour_units_i,
    input logic [TENS_W-1:0] min_tens_i,
    input logic [DIG_W-1:0]  min_units_i,
    input logic [TENS_W-1:0] sec_tens_i,
    input logic [DIG_W-1:0]  sec_units_i,
    input logic [CHAR_W-1:0] ch_ap_o,
    input logic [CHAR_W-1:0] ch_m_o,
    input logic [CHAR_W-1:0] ch_hr_tens_o,
    input logic [CHAR_W-1:0] ch_hr_units_o,
    input logic [CHAR_W-1:0] ch_mn_tens_o,
    input logic [CHAR_W-1:0] ch_mn_units_o,
    input logic [CHAR_W-1:0] ch_colon_o,
    input logic [CHAR_W-1:0] ch_sc_tens_o,
    input logic [CHAR_W-1:0] ch_sc_units_o
);

    logic one_set;
    logic in_norm;

    always_comb begin
        one_set = $onehot(mode_i);
        in_norm = !one_set || mode_i[MB_NORM];

        AST_M_CHAR_SET: assert (ch_m_o == CH_M || ch_m_o == CH_SPACE); // R1
        AST_HRTENS_ZERO_BLANK: assert (hour_tens_i || ch_hr_tens_o == CH_SPACE); // R3
        AST_INIT_ALL_HIDDEN: assert (!(one_set && mode_i[MB_INIT] && !blink_on_i)
            || (ch_ap_o == CH_SPACE && ch_hr_units_o == CH_SPACE && ch_mn_units_o == CH_SPACE)); // R4
        AST_APSET_HOUR_SHOWN: assert (!(one_set && mode_i[MB_APSET])
            || ch_hr_units_o != CH_SPACE); // R5
        AST_NORM_COLON: assert (!in_norm || ch_colon_o == CH_COLON); // R9
        AST_NORM_NOTHING_HIDDEN: assert (!in_norm
            || (ch_m_o == CH_M && ch_mn_tens_o != CH_SPACE && ch_sc_units_o != CH_SPACE)); // R11
        AST_SECS_BLANK: assert (in_norm
            || (ch_colon_o == CH_SPACE && ch_sc_tens_o == CH_SPACE && ch_sc_units_o == CH_SPACE)); // R10
    end

endmodule

bind clk_disp_fmt clk_disp_fmt_chk #(.DIG_W(DIG_W), .TENS_W(TENS_W)) u_chk (
    .mode_i        (mode_i),
    .blink_on_i    (blink_on_i),
    .ampm_i        (ampm_i),
    .hour_tens_i   (hour_tens_i),
    .hour_units_i  (hour_units_i),
    .min_tens_i    (min_tens_i),
    .min_units_i   (min_units_i),
    .sec_tens_i    (sec_tens_i),
    .sec_units_i   (sec_units_i),
    .ch_ap_o       (ch_ap_o),
    .ch_m_o        (ch_m_o),
    .ch_hr_tens_o  (ch_hr_tens_o),
    .ch_hr_units_o (ch_hr_units_o),
    .ch_mn_tens_o  (ch_mn_tens_o),
    .ch_mn_units_o (ch_mn_units_o),
    .ch_colon_o    (ch_colon_o),
    .ch_sc_tens_o  (ch_sc_tens_o),
    .ch_sc_units_o (ch_sc_units_o)
);

// File: tb/clk_disp_fmt_bench.sv
module clk_disp_fmt_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic [5:0] mode;
    logic       blink, ampm, ht;
    logic [3:0] hu, mu, su;
    logic [2:0] mt, st;
    logic [7:0] o_ap, o_m, o_ht, o_hu, o_mt, o_mu, o_col, o_st, o_su;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    clk_disp_fmt u_clk_disp_fmt (
        .mode_i(mode), .blink_on_i(blink), .ampm_i(ampm), .hour_tens_i(ht),
        .hour_units_i(hu), .min_tens_i(mt), .min_units_i(mu),
        .sec_tens_i(st), .sec_units_i(su),
        .ch_ap_o(o_ap), .ch_m_o(o_m), .ch_hr_tens_o(o_ht), .ch_hr_units_o(o_hu),
        .ch_mn_tens_o(o_mt), .ch_mn_units_o(o_mu), .ch_colon_o(o_col),
        .ch_sc_tens_o(o_st), .ch_sc_units_o(o_su)
    );

    // {mode[5:0], blink, ampm, ht, hu[3:0], mt[2:0], mu[3:0], st[2:0], su[3:0]}
    localparam int NV = 20;
    localparam logic [26:0] VEC [NV] = '{
        {6'b100000, 1'b1, 1'b0, 1'b1, 4'd2, 3'd3, 4'd4, 3'd5, 4'd6},
        {6'b100000, 1'b0, 1'b1, 1'b0, 4'd9, 3'd5, 4'd9, 3'd5, 4'd9},
        {6'b100000, 1'b1, 1'b1, 1'b1, 4'd0, 3'd0, 4'd0, 3'd0, 4'd0},
        {6'b000001, 1'b0, 1'b0, 1'b1, 4'd2, 3'd0, 4'd0, 3'd1, 4'd7},
        {6'b000001, 1'b1, 1'b0, 1'b1, 4'd2, 3'd0, 4'd0, 3'd1, 4'd7},
        {6'b000010, 1'b0, 1'b1, 1'b0, 4'd7, 3'd2, 4'd8, 3'd3, 4'd1},
        {6'b000010, 1'b1, 1'b1, 1'b0, 4'd7, 3'd2, 4'd8, 3'd3, 4'd1},
        {6'b000100, 1'b0, 1'b0, 1'b1, 4'd1, 3'd4, 4'd5, 3'd2, 4'd2},
        {6'b000100, 1'b1, 1'b0, 1'b1, 4'd1, 3'd4, 4'd5, 3'd2, 4'd2},
        {6'b000100, 1'b0, 1'b1, 1'b0, 4'd3, 3'd1, 4'd6, 3'd0, 4'd0},
        {6'b001000, 1'b0, 1'b0, 1'b0, 4'd5, 3'd5, 4'd3, 3'd4, 4'd4},
        {6'b001000, 1'b1, 1'b0, 1'b0, 4'd5, 3'd5, 4'd3, 3'd4, 4'd4},
        {6'b010000, 1'b0, 1'b1, 1'b1, 4'd1, 3'd3, 4'd9, 3'd1, 4'd8},
        {6'b010000, 1'b1, 1'b1, 1'b1, 4'd1, 3'd3, 4'd9, 3'd1, 4'd8},
        {6'b100000, 1'b0, 1'b0, 1'b0, 4'd8, 3'd2, 4'd1, 3'd5, 4'd3},
        {6'b000000, 1'b0, 1'b1, 1'b1, 4'd0, 3'd1, 4'd2, 3'd3, 4'd5},
        {6'b000011, 1'b0, 1'b0, 1'b0, 4'd4, 3'd0, 4'd7, 3'd4, 4'd6},
        {6'b110000, 1'b0, 1'b1, 1'b1, 4'd2, 3'd5, 4'd8, 3'd2, 4'd9},
        {6'b111111, 1'b0, 1'b0, 1'b0, 4'd6, 3'd4, 4'd4, 3'd0, 4'd1},
        {6'b100000, 1'b1, 1'b1, 1'b0, 4'd9, 3'd0, 4'd5, 3'd5, 4'd0}
    };

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic apply_and_check(input logic [26:0] v);
        logic [5:0] m;
        logic       hap, hhr, hmt, hmu, nrm;
        string      mt_tag;
        @(negedge clk);
        {mode, blink, ampm, ht, hu, mt, mu, st, su} = v;
        #1;
        // independent expectation
        if ($countones(mode) == 1) m = mode; else m = 6'b100000;
        hap = !blink && (m[0] || m[1]);
        hhr = !blink && (m[0] || m[2]);
        hmt = !blink && (m[0] || m[3]);
        hmu = !blink && (m[0] || m[4]);
        nrm = m[5];
        if ($countones(mode) != 1) mt_tag = "R11";
        else if (m[0]) mt_tag = "R4";
        else if (m[1]) mt_tag = "R5";
        else if (m[2]) mt_tag = "R6";
        else if (m[3]) mt_tag = "R7";
        else if (m[4]) mt_tag = "R8";
        else mt_tag = "R9";
        chk(o_ap,  hap ? 8'h20 : (ampm ? 8'h50 : 8'h41), {"R1 ap/", mt_tag});
        chk(o_m,   hap ? 8'h20 : 8'h4D,                  {"R1 m/", mt_tag});
        chk(o_ht,  (hhr || !ht) ? 8'h20 : 8'h31,         {"R3 hr tens/", mt_tag});
        chk(o_hu,  hhr ? 8'h20 : 8'h30 + {4'h0, hu},     {"R2 hr units/", mt_tag});
        chk(o_mt,  hmt ? 8'h20 : 8'h30 + {5'h0, mt},     {"R2 min tens/", mt_tag});
        chk(o_mu,  hmu ? 8'h20 : 8'h30 + {4'h0, mu},     {"R2 min units/", mt_tag});
        chk(o_col, nrm ? 8'h3A : 8'h20,                  {"R10 colon/", mt_tag});
        chk(o_st,  nrm ? 8'h30 + {5'h0, st} : 8'h20,     {"R10 sec tens/", mt_tag});
        chk(o_su,  nrm ? 8'h30 + {4'h0, su} : 8'h20,     {"R10 sec units/", mt_tag});
    endtask

    initial begin
        {mode, blink, ampm, ht, hu, mt, mu, st, su} = '0;
        repeat (3) @(posedge clk);
        // idle inputs: all-zero mode falls back to normal display of 00:00 AM
        #1;
        chk(o_ap,  8'h41, "R11 idle ap");
        chk(o_ht,  8'h20, "R3 idle hr tens");
        chk(o_col, 8'h3A, "R11 idle colon");
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) apply_and_check(VEC[i]);
        // directed corners
        apply_and_check({6'b100000, 1'b0, 1'b1, 1'b1, 4'd1, 3'd5, 4'd9, 3'd5, 4'd9});
        chk(o_ht, 8'h31, "R9 hr tens one visible in normal");
        chk(o_ap, 8'h50, "R1 pm marker");
        apply_and_check({6'b000100, 1'b0, 1'b0, 1'b1, 4'd2, 3'd0, 4'd0, 3'd0, 4'd0});
        chk(o_ht, 8'h20, "R6 hr tens hidden");
        chk(o_ap, 8'h41, "R6 marker stays visible");
        apply_and_check({6'b000001, 1'b1, 1'b0, 1'b1, 4'd2, 3'd0, 4'd0, 3'd3, 4'd3});
        chk(o_su, 8'h20, "R10 seconds blank in initial with blink on");
        apply_and_check({6'b001000, 1'b0, 1'b0, 1'b0, 4'd9, 3'd2, 4'd3, 3'd1, 4'd1});
        chk(o_mu, 8'h33, "R7 minute units untouched");
        apply_and_check({6'b010000, 1'b0, 1'b0, 1'b0, 4'd9, 3'd2, 4'd3, 3'd1, 4'd1});
        chk(o_mt, 8'h32, "R8 minute tens untouched");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule